// File: doc/BRIEF.md
# Bulk-In Acknowledge and Retransmit Controller

This block sits beside the FIFO read side of a bulk-in endpoint. It tracks whether the last packet handed to the host is still waiting for an acknowledge. It drives the DATA0/DATA1 toggle. For every IN token it decides whether the reply is a resend of the held packet, fresh data, or a NAK. A missing acknowledge arrives as a timeout event, which comes before the next IN token. The timeout causes a one-cycle rewind pulse to the FIFO controller so that the same bytes are read out again. An acknowledge causes a one-cycle advance pulse, so the FIFO controller moves its read head past the packet.

A packet that ends a transfer (a short packet or a zero-length packet) is flagged at send time. Until that packet is acknowledged, the block offers no new data, even if a new frame is waiting. The toggle also stays where it is, so the old toggle value cannot start a new transfer. The responder has no stall reply. The asynchronous active-low reset is released through a small synchronizer.

Top module: `bir_retx_ctrl`

## Requirements
- R1: After reset, the block is idle. data_tgl is 0 (DATA0). rewind_p, advance_p, resp_vld, sel_retx and eot_held are 0.
- R2: A host_tmo while a packet is awaiting acknowledge gives rewind_p high for exactly the next cycle. data_tgl does not change.
- R3: After a rewind, sel_retx is 1, and an IN token is answered one cycle later with resp_code 2 (resend). Sending the packet again returns the block to awaiting acknowledge.
- R4: A host_ack while a packet is awaiting acknowledge gives advance_p high for exactly the next cycle, and data_tgl inverts in that same cycle. data_tgl changes at no other time.
- R5: When the held packet was sent with pkt_eot=1, eot_held stays 1 until it is acknowledged. While eot_held is 1, resends continue and new_ok stays 0, even with frame_avail=1.
- R6: new_ok is 1 only when no packet is held and frame_avail is 1. An IN token in that state is answered with resp_code 1 (new data). An IN token with no packet held and frame_avail=0 is answered with resp_code 0 (NAK).
- R7: host_ack and host_tmo have no effect when no packet is awaiting acknowledge: no pulse, no toggle change.
- R8: resp_code is never 3 (the stall reply).
- R9: When host_ack and host_tmo arrive together while awaiting acknowledge, the acknowledge wins.
- R10: An IN token while a packet is awaiting acknowledge is answered with resp_code 0 (NAK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_sent | input | 1 | Strobe: a bulk-in packet was handed to the host |
| pkt_eot | input | 1 | With pkt_sent: the packet ends the transfer |
| host_ack | input | 1 | Strobe: host acknowledged the outstanding packet |
| host_tmo | input | 1 | Strobe: no acknowledge before the next token |
| in_tok | input | 1 | Strobe: IN token received |
| frame_avail | input | 1 | A new frame is ready in the FIFO |
| rewind_p | output | 1 | One-cycle pulse: rewind the FIFO read pointer |
| advance_p | output | 1 | One-cycle pulse: advance the FIFO read head |
| data_tgl | output | 1 | Current data toggle (0 = DATA0) |
| sel_retx | output | 1 | Next packet is a resend of the held one |
| eot_held | output | 1 | Held packet ends a transfer |
| new_ok | output | 1 | New data may be offered |
| resp_vld | output | 1 | Token reply valid, one cycle after in_tok |
| resp_code | output | 2 | 0 NAK, 1 new data, 2 resend |

## Verification
All results are registered, so rewind_p, advance_p, data_tgl, sel_retx, eot_held and the token reply become valid in the cycle after the clock edge that samples their stimulus. new_ok follows frame_avail combinationally on top of that registered state. The bench drives each stimulus on the falling edge and samples one time unit after the next rising edge. At that point it compares every output against a cycle-by-cycle reference model written from the requirements. The reference model is stepped once per edge. Directed sequences hit the resend-until-acknowledge, simultaneous-event and stray-event cases. After them, a pseudo-random sweep of several thousand cycles covers all input combinations from every state.

// File: rtl/bir_pkg.sv
package bir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RETX = 2'd2
  } bir_st_e;

  typedef enum logic [1:0] {
    RSP_NAK   = 2'd0,
    RSP_NEW   = 2'd1,
    RSP_RETX  = 2'd2,
    RSP_STALL = 2'd3
  } bir_rsp_e;

  localparam int unsigned RSP_W = 2;
endpackage

// File: rtl/bir_rst_sync.sv
module bir_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/bir_track.sv
module bir_track
  import bir_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pkt_sent,
  input  logic    pkt_eot,
  input  logic    host_ack,
  input  logic    host_tmo,
  output bir_st_e st_q,
  output logic    eot_q,
  output logic    ack_evt,
  output logic    rewind_p,
  output logic    advance_p
);
  bir_st_e st_d;
  logic    eot_d;
  logic    tmo_evt;
  logic    st_en;

  // acknowledge beats timeout when both arrive together
  assign ack_evt = (st_q == ST_WAIT) && host_ack;
  assign tmo_evt = (st_q == ST_WAIT) && host_tmo && !host_ack;

  always_comb begin
    st_d  = st_q;
    eot_d = eot_q;
    unique case (st_q)
      ST_IDLE: if (pkt_sent) begin
        st_d  = ST_WAIT;
        eot_d = pkt_eot;
      end
      ST_WAIT: begin
        if (ack_evt) begin
          st_d  = ST_IDLE;
          eot_d = 1'b0;
        end else if (tmo_evt) begin
          st_d = ST_RETX;
        end
      end
      ST_RETX: if (pkt_sent) st_d = ST_WAIT;
      default: begin
        st_d  = ST_IDLE;
        eot_d = 1'b0;
      end
    endcase
  end

  assign st_en = (st_d != st_q) || (eot_d != eot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      eot_q <= 1'b0;
    end else if (st_en) begin
      st_q  <= st_d;
      eot_q <= eot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rewind_p  <= 1'b0;
      advance_p <= 1'b0;
    end else begin
      rewind_p  <= tmo_evt;
      advance_p <= ack_evt;
    end
  end
endmodule

// File: rtl/bir_toggle.sv
module bir_toggle #(
  parameter logic TGL_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  output logic data_tgl
);
  logic tgl_d;

  always_comb tgl_d = ~data_tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_tgl <= TGL_RST;
    else if (ack_evt) data_tgl <= tgl_d;
  end
endmodule

// File: rtl/bir_resp.sv
module bir_resp
  import bir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tok,
  input  bir_st_e          st_q,
  input  logic             frame_avail,
  output logic             resp_vld,
  output logic [RSP_W-1:0] resp_code
);
  bir_rsp_e code_d;

  always_comb begin
    unique case (st_q)
      ST_IDLE: code_d = frame_avail ? RSP_NEW : RSP_NAK;
      ST_RETX: code_d = RSP_RETX;
      default: code_d = RSP_NAK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_vld <= 1'b0;
    else        resp_vld <= in_tok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      resp_code <= RSP_NAK;
    else if (in_tok) resp_code <= code_d;
  end
endmodule

// File: rtl/bir_retx_ctrl.sv
module bir_retx_ctrl
  import bir_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        TGL_RST     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_sent,
  input  logic             pkt_eot,
  input  logic             host_ack,
  input  logic             host_tmo,
  input  logic             in_tok,
  input  logic             frame_avail,
  output logic             rewind_p,
  output logic             advance_p,
  output logic             data_tgl,
  output logic             sel_retx,
  output logic             eot_held,
  output logic             new_ok,
  output logic             resp_vld,
  output logic [RSP_W-1:0] resp_code
);
  logic    rst_sn;
  bir_st_e st_q;
  logic    ack_evt;

  bir_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  bir_track u_track (
    .clk(clk), .rst_n(rst_sn), .pkt_sent(pkt_sent), .pkt_eot(pkt_eot),
    .host_ack(host_ack), .host_tmo(host_tmo), .st_q(st_q), .eot_q(eot_held),
    .ack_evt(ack_evt), .rewind_p(rewind_p), .advance_p(advance_p)
  );

  bir_toggle #(.TGL_RST(TGL_RST)) u_tgl (
    .clk(clk), .rst_n(rst_sn), .ack_evt(ack_evt), .data_tgl(data_tgl)
  );

  bir_resp u_resp (
    .clk(clk), .rst_n(rst_sn), .in_tok(in_tok), .st_q(st_q),
    .frame_avail(frame_avail), .resp_vld(resp_vld), .resp_code(resp_code)
  );

  assign sel_retx = (st_q == ST_RETX);
  assign new_ok   = (st_q == ST_IDLE) && frame_avail;
endmodule

// File: rtl/bir_retx_ctrl_chk.sv
module bir_retx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_tok,
  input logic       rewind_p,
  input logic       advance_p,
  input logic       data_tgl,
  input logic       sel_retx,
  input logic       eot_held,
  input logic       new_ok,
  input logic       resp_vld,
  input logic [1:0] resp_code
);
  // R2
  rewind_keeps_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_p |-> data_tgl == $past(data_tgl));

  // R4
  advance_flips_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance_p |-> data_tgl != $past(data_tgl));

  // R4
  tgl_only_on_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_tgl != $past(data_tgl)) |-> advance_p);

  // R8
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> resp_code != 2'd3);

  // R3
  retx_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_retx && in_tok) |=> (resp_vld && resp_code == 2'd2));

  // R5
  eot_blocks_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_held |-> !new_ok);

  // R6
  new_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_ok |-> !sel_retx);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rewind_p && advance_p));
endmodule

bind bir_retx_ctrl bir_retx_ctrl_chk u_chk (.*);

// File: tb/bir_retx_ctrl_test.sv
module bir_retx_ctrl_test;
  localparam int CLK_P = 10;

  logic clk, rst_n;
  logic pkt_sent, pkt_eot, host_ack, host_tmo, in_tok, frame_avail;
  logic rewind_p, advance_p, data_tgl, sel_retx, eot_held, new_ok, resp_vld;
  logic [1:0] resp_code;

  int checks, errors;
  bit done;

  // reference model: 0 idle, 1 awaiting ack, 2 resend pending
  int   m_st;
  logic m_eot, m_tgl, m_rew, m_adv, m_vld;
  logic [1:0] m_code;

  bir_retx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pkt_sent(pkt_sent), .pkt_eot(pkt_eot),
    .host_ack(host_ack), .host_tmo(host_tmo), .in_tok(in_tok),
    .frame_avail(frame_avail), .rewind_p(rewind_p), .advance_p(advance_p),
    .data_tgl(data_tgl), .sel_retx(sel_retx), .eot_held(eot_held),
    .new_ok(new_ok), .resp_vld(resp_vld), .resp_code(resp_code)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic void chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  task automatic step(input logic ps, input logic pe, input logic ak,
                      input logic tm, input logic tk, input logic fa);
    @(negedge clk);
    pkt_sent = ps; pkt_eot = pe; host_ack = ak;
    host_tmo = tm; in_tok = tk; frame_avail = fa;
    m_vld = tk;
    if (tk) m_code = (m_st == 0) ? {1'b0, fa} : (m_st == 2) ? 2'd2 : 2'd0;
    m_rew = 1'b0; m_adv = 1'b0;
    case (m_st)
      0: if (ps) begin m_st = 1; m_eot = pe; end
      1: if (ak) begin m_adv = 1'b1; m_tgl = ~m_tgl; m_st = 0; m_eot = 1'b0; end
         else if (tm) begin m_rew = 1'b1; m_st = 2; end
      default: if (ps) m_st = 1;
    endcase
    @(posedge clk);
    #1;
    chk("R2 rewind_p", {1'b0, rewind_p}, {1'b0, m_rew});
    chk("R4 advance_p", {1'b0, advance_p}, {1'b0, m_adv});
    chk("R4 data_tgl", {1'b0, data_tgl}, {1'b0, m_tgl});
    chk("R3 sel_retx", {1'b0, sel_retx}, {1'b0, m_st == 2});
    chk("R5 eot_held", {1'b0, eot_held}, {1'b0, m_eot});
    chk("R6 new_ok", {1'b0, new_ok}, {1'b0, (m_st == 0) && fa});
    chk("R6 resp_vld", {1'b0, resp_vld}, {1'b0, m_vld});
    if (m_vld) chk("R3 R6 R10 resp_code", resp_code, m_code);
    if (resp_vld) chk("R8 no stall", {1'b0, resp_code == 2'd3}, 2'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    checks = 0; errors = 0; done = 1'b0;
    m_st = 0; m_eot = 1'b0; m_tgl = 1'b0; m_code = 2'd0; m_vld = 1'b0;
    m_rew = 1'b0; m_adv = 1'b0;
    rst_n = 1'b0;
    pkt_sent = 0; pkt_eot = 0; host_ack = 0; host_tmo = 0; in_tok = 0; frame_avail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0);
    // R1 reset state
    chk("R1 data_tgl", {1'b0, data_tgl}, 2'd0);
    chk("R1 sel_retx", {1'b0, sel_retx}, 2'd0);
    chk("R1 eot_held", {1'b0, eot_held}, 2'd0);
    chk("R1 pulses", {rewind_p, advance_p}, 2'd0);

    // R7 stray ack and timeout in idle
    step(0, 0, 1, 1, 0, 0);
    chk("R7 no pulse", {rewind_p, advance_p}, 2'd0);
    chk("R7 toggle", {1'b0, data_tgl}, 2'd0);
    // R6 token with and without frame
    step(0, 0, 0, 0, 1, 1);
    chk("R6 new reply", resp_code, 2'd1);
    step(0, 0, 0, 0, 1, 0);
    chk("R6 nak reply", resp_code, 2'd0);
    // R5: end-of-transfer packet, timeout, repeated while frames wait
    step(1, 1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    chk("R10 nak while waiting", resp_code, 2'd0);
    step(0, 0, 0, 1, 0, 1);
    chk("R2 rewind", {1'b0, rewind_p}, 2'd1);
    step(0, 0, 0, 0, 1, 1);
    chk("R5 repeat despite frame", resp_code, 2'd2);
    chk("R5 new blocked", {1'b0, new_ok}, 2'd0);
    step(1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 1);
    step(1, 0, 0, 0, 1, 1);
    chk("R5 still held", {1'b0, eot_held}, 2'd1);
    // R9 ack and timeout together
    step(0, 0, 1, 1, 0, 1);
    chk("R9 ack wins", {rewind_p, advance_p}, 2'd1);
    chk("R4 toggle flipped", {1'b0, data_tgl}, 2'd1);
    chk("R5 released", {1'b0, new_ok}, 2'd1);

    // pseudo-random sweep over all input combinations
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2] & lfsr[7], lfsr[3], lfsr[4], lfsr[5]);
    end
    finish_run();
  end
endmodule